// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is an up-counter made of identical 4-bit stages that all change state on the same rising clock edge. Each stage supports a synchronous parallel preset, an asynchronous active-low clear and two count enables. The top module links a parameterised number of stages so that they behave as one wide synchronous binary counter. Inside the top module, each stage's carry output drives the carry-side enable of the stage above it, so the chain needs no extra gating.

The two enables have different jobs. The shared enable (`en_p`) only allows counting. The carry-side enable (`en_t`) allows counting and also enables the carry output. A carry therefore appears only when every stage below is at its maximum and the chain is enabled at its base. Preset takes priority over counting. The clear overrides everything and acts without waiting for a clock edge.

Top module: `ctr_cascade`

## Requirements
- R1: While `clr_n` is 0, `q` is all zeros without waiting for a clock edge, whatever the levels of `clk`, `load_n`, `en_p` and `en_t`.
- R2: When `load_n` is 0 at a rising edge, `q` takes the value of `preset` on that edge, whatever the levels of `en_p` and `en_t`. Any value from zero to all ones can be preset.
- R3: When `load_n` is 1 and both `en_p` and `en_t` are 1 at a rising edge, `q` becomes its previous value plus one.
- R4: When `load_n` is 1 and either `en_p` or `en_t` is 0 at a rising edge, `q` keeps its value.
- R5: `carry_out` is 1 exactly when `q` is all ones and `en_t` is 1. It is 0 in every other case, and `en_p` has no effect on it.
- R6: A count step from all ones wraps `q` to all zeros.
- R7: Changes on `load_n`, `en_p` or `en_t` between clock edges leave `q` unchanged. Only the levels present at the rising edge select the action.
- R8: With `STAGES` stages of 4 bits each, `q` counts as one binary number of 4×`STAGES` bits. A stage advances only on the edge where every stage below it is at all ones.
- R9: `carry_out` is combinational and follows `q` and `en_t` within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous preset, active low |
| en_p | input | 1 | Shared count enable |
| en_t | input | 1 | Count enable that also enables the carry |
| preset | input | STAGE_W*STAGES | Preset value |
| q | output | STAGE_W*STAGES | Current count |
| carry_out | output | 1 | High when count is all ones and en_t is high |

## Verification
The hardest condition to reach from the ports is a carry that passes through a stage boundary while the upper stage itself is at all ones, because this tests the carry chain and the wrap at the same time. The bench presets every value of the 8-bit configuration. Among these are 0x0F, 0xFF and values just below them. From each preset it takes single count steps, so every boundary crossing and the full wrap are reached directly instead of after long runs. Separate steps pulse the enables and the preset strobe between edges, and pulse the clear between edges.

// File: rtl/ctr_pkg.sv
`timescale 1ns/1ps
// ctr_pkg: shared mode type and decode for the counter stages.
// Assumes active-low preset strobe with priority over the enables.
package ctr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2
    } ctr_mode_e;

    // Pick the action for one edge: preset first, then count, else hold.
    function automatic ctr_mode_e pick_mode(input logic load_n,
                                            input logic en_p,
                                            input logic en_t);
        if (!load_n)
            return MODE_LOAD;
        else if (en_p && en_t)
            return MODE_COUNT;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/ctr_stage_next.sv
`timescale 1ns/1ps
// ctr_stage_next: combinational next-state and carry for one stage.
// Assumes the caller registers nxt; carry depends on the current value only.
module ctr_stage_next #(
    parameter int STAGE_W = 4
) (
    input  logic [STAGE_W-1:0] cur,
    input  logic [STAGE_W-1:0] preset,
    input  logic               load_n,
    input  logic               en_p,
    input  logic               en_t,
    output logic [STAGE_W-1:0] nxt,
    output logic               rco
);
    import ctr_pkg::*;

    localparam logic [STAGE_W-1:0] ONE = STAGE_W'(1);

    ctr_mode_e mode;

    // Decode the action requested for the coming edge.
    always_comb mode = pick_mode(load_n, en_p, en_t);

    // Form the value the register takes on the coming edge.
    always_comb begin
        unique case (mode)
            MODE_LOAD:  nxt = preset;
            MODE_COUNT: nxt = cur + ONE;
            default:    nxt = cur;
        endcase
    end

    // Carry: terminal count gated by the carry-side enable only.
    always_comb rco = (&cur) & en_t;

endmodule

// File: rtl/ctr_stage.sv
`timescale 1ns/1ps
// ctr_stage: one presettable counter stage with an asynchronous clear.
// Assumes clr_n is the only asynchronous input; all else is edge-sampled.
module ctr_stage #(
    parameter int STAGE_W = 4
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic               en_p,
    input  logic               en_t,
    input  logic [STAGE_W-1:0] preset,
    output logic [STAGE_W-1:0] q,
    output logic               rco
);
    logic [STAGE_W-1:0] nxt;

    ctr_stage_next #(.STAGE_W(STAGE_W)) u_next (
        .cur    (q),
        .preset (preset),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .nxt    (nxt),
        .rco    (rco)
    );

    // State register: all bits update together, cleared without a clock.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            q <= '0;
        else
            q <= nxt;
    end

endmodule

// File: rtl/ctr_cascade.sv
`timescale 1ns/1ps
// ctr_cascade: STAGES counter stages chained into one wide binary counter.
// Assumes en_p is shared by all stages; stage 0 takes en_t and every later
// stage takes the carry of the stage below as its carry-side enable.
module ctr_cascade #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 2
) (
    input  logic                        clk,
    input  logic                        clr_n,
    input  logic                        load_n,
    input  logic                        en_p,
    input  logic                        en_t,
    input  logic [STAGE_W*STAGES-1:0]   preset,
    output logic [STAGE_W*STAGES-1:0]   q,
    output logic                        carry_out
);
    localparam int TOTAL_W = STAGE_W * STAGES;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic               ent_l;
        logic               rco_l;
        logic [STAGE_W-1:0] q_l;

        // Carry-side enable: the base input for stage 0, else carry below.
        if (i == 0) begin : g_base
            assign ent_l = en_t;
        end else begin : g_link
            assign ent_l = g_stage[i-1].rco_l;
        end

        ctr_stage #(.STAGE_W(STAGE_W)) u_stage (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .en_p   (en_p),
            .en_t   (ent_l),
            .preset (preset[i*STAGE_W +: STAGE_W]),
            .q      (q_l),
            .rco    (rco_l)
        );

        assign q[i*STAGE_W +: STAGE_W] = q_l;
    end

    // The chain's carry is the carry of the top stage.
    assign carry_out = g_stage[STAGES-1].rco_l;

endmodule

// File: rtl/ctr_cascade_chk.sv
`timescale 1ns/1ps
// ctr_cascade_chk: port-level properties of the cascaded counter.
// Assumes it is bound to ctr_cascade and watches only its ports.
module ctr_cascade_chk #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 2
) (
    input logic                        clk,
    input logic                        clr_n,
    input logic                        load_n,
    input logic                        en_p,
    input logic                        en_t,
    input logic [STAGE_W*STAGES-1:0]   preset,
    input logic [STAGE_W*STAGES-1:0]   q,
    input logic                        carry_out
);
    localparam int TW = STAGE_W * STAGES;
    localparam logic [TW-1:0] ONE = TW'(1);

    // R1: clear holds the count at zero, checked mid-cycle.
    always @(negedge clk) begin
        if (clr_n == 1'b0) begin
            p_clear_zero_r1: assert (q == '0);
        end
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(preset));

    // R3, R6, R8: a count step advances the whole chain by one, wrapping.
    p_count_step_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t) |=> q == $past(q) + ONE);

    p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_p && en_t)) |=> $stable(q));

    // R5, R9: carry follows count and en_t in the same cycle.
    p_carry_r5: assert property (@(negedge clk) disable iff (!clr_n)
        carry_out == ((&q) && en_t));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t && (&q)) |=> q == '0);

endmodule

bind ctr_cascade ctr_cascade_chk #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .en_p      (en_p),
    .en_t      (en_t),
    .preset    (preset),
    .q         (q),
    .carry_out (carry_out)
);

// File: tb/ctr_cascade_tb.sv
`timescale 1ns/1ps
// ctr_cascade_tb: sweep of every preset value on a two-stage chain.
module ctr_cascade_tb;
    localparam int SW = 4;
    localparam int NS = 2;
    localparam int TW = SW * NS;
    localparam logic [TW-1:0] MAXV = '1;

    logic          clk = 1'b0;
    logic          clr_n = 1'b1;
    logic          load_n = 1'b1;
    logic          en_p = 1'b0;
    logic          en_t = 1'b0;
    logic [TW-1:0] preset = '0;
    logic [TW-1:0] q;
    logic          carry_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [TW-1:0] exp_q;
    bit done = 0;

    ctr_cascade #(.STAGE_W(SW), .STAGES(NS)) u_dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p),
        .en_t(en_t), .preset(preset), .q(q), .carry_out(carry_out)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        #1 clr_n = 1'b0;
        #1 check("R1 reset", int'(q), 0);
        tick();
        clr_n = 1'b1;
        check("R1 reset carry", int'(carry_out), 0);
        exp_q = '0;

        // Sweep every preset value.
        for (int v = 0; v <= int'(MAXV); v++) begin
            load_n = 1'b0;
            preset = TW'(v);
            en_p = v[0];
            en_t = v[1];
            tick();
            exp_q = TW'(v);
            check("R2 load", int'(q), int'(exp_q));
            load_n = 1'b1;
            preset = ~TW'(v);
            // R5: carry over all enable combinations, same cycle (R9).
            for (int c = 0; c < 4; c++) begin
                en_p = c[0];
                en_t = c[1];
                #0.4;
                check("R5 carry", int'(carry_out), int'((exp_q == MAXV) && c[1]));
            end
            // R4: each non-count combination holds.
            for (int c = 0; c < 3; c++) begin
                en_p = c[0];
                en_t = c[1];
                tick();
                check("R4 hold", int'(q), int'(exp_q));
            end
            // R3 / R6 / R8: one step across any boundary.
            en_p = 1'b1;
            en_t = 1'b1;
            tick();
            exp_q = exp_q + TW'(1);
            check(v == int'(MAXV) ? "R6 wrap" : "R3 R8 step", int'(q), int'(exp_q));
        end

        // R8: long continuous run through several stage carries and a wrap.
        load_n = 1'b0;
        preset = TW'(8'hF0);
        tick();
        load_n = 1'b1;
        exp_q = TW'(8'hF0);
        for (int k = 0; k < 300; k++) begin
            tick();
            exp_q = exp_q + TW'(1);
            check("R8 run", int'(q), int'(exp_q));
        end

        // R7: pulses between edges do not change the count.
        en_p = 1'b0;
        en_t = 1'b0;
        preset = TW'(8'h3C);
        tick();
        check("R7 setup", int'(q), int'(exp_q));
        for (int k = 0; k < 4; k++) begin
            en_p = 1'b1;
            en_t = 1'b1;
            load_n = 1'b0;
            #1;
            en_p = 1'b0;
            en_t = 1'b0;
            load_n = 1'b1;
            tick();
            check("R7 between edges", int'(q), int'(exp_q));
        end

        // R1: clear between edges, with load and count requested.
        load_n = 1'b0;
        en_p = 1'b1;
        en_t = 1'b1;
        preset = TW'(8'hA5);
        #0.5 clr_n = 1'b0;
        #0.5 check("R1 async clear", int'(q), 0);
        tick();
        check("R1 clear over edge", int'(q), 0);
        clr_n = 1'b1;
        load_n = 1'b1;
        tick();
        check("R1 count after clear", int'(q), 1);

        finish_run();
    end
endmodule